// File: doc/BRIEF.md
# 64-bit Cycle Counter with Consistent Split Read

This block keeps a 64-bit count of clock cycles and exposes it on a 32-bit register bus as three words: a control word, a lower count word and an upper count word. Software turns counting on by writing the control word. It reads the 64-bit value in three steps: the lower word, then the upper word, then the control word.

Reading the lower word captures the full 64-bit count into a snapshot. The upper-word read returns the snapshot's top half, so a carry between the two reads cannot tear the pair. The top bit of the control word tells software whether the pair it just read is still valid. A write to either count word, or a change of the enable bit, after the lower-word read clears that bit, and software then repeats the three reads. The counter keeps running throughout.

Top module: `cyc_counter64`

## Requirements
- R1: After synchronous reset the counter is disabled, the count is zero, and reads of the control word, the lower word and the upper word all return zero.
- R2: Writing the control word (address 0x103) sets the enable from write-data bit 0. A control read returns the enable in bit 0 and the pair-valid flag in bit 31, and bits 30 down to 1 read as zero.
- R3: While enabled, the count rises by exactly one on each clock edge. While disabled, the count holds.
- R4: The count wraps from all ones to zero.
- R5: A read of the lower word (address 0x104) returns bits 31:0 of the count and captures all 64 bits as a snapshot. A later read of the upper word (address 0x105) returns bits 63:32 of that snapshot, even if the live count has carried into its upper half since.
- R6: A lower-word read sets the pair-valid flag, so a control read after it returns bit 31 = 1. Every control read clears the flag.
- R7: A write to the lower or upper count word after a lower-word read clears the pair-valid flag, so the next control read returns bit 31 = 0.
- R8: A control write that changes the enable clears the pair-valid flag. A control write that leaves the enable unchanged keeps the flag.
- R9: A write to a count word loads that half of the count on the next edge, and the load takes priority over that edge's increment.
- R10: Reads of any other address return zero. Writes to any other address change neither the count, the enable nor the flag.
- R11: A control read with no lower-word read since the last control read returns bit 31 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe; read side effects take place at the clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address presented, combinational |

## Verification
The hardest case to reach from the ports is a lower-word read just before a carry into the upper half, followed by the upper-word read after that carry. The bench loads the count a few cycles below the 32-bit boundary by writing the count words. It then sweeps both the starting offset and the number of idle cycles between the lower and upper reads, so that the carry falls before, between and after the reads. Disturbing writes are placed between the lower-word read and the control read to check that the flag is withdrawn.

// File: rtl/cc_pkg.sv
package cc_pkg;

    // Which register a bus access addresses
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_LO   = 2'd2,
        SEL_HI   = 2'd3
    } sel_e;

    // Decoded bus access
    typedef struct packed {
        logic rd;
        logic wr;
        sel_e sel;
    } acc_t;

    localparam int CTRL_EN_BIT = 0;

    function automatic logic is_cnt_write(acc_t a);
        return a.wr && (a.sel == SEL_LO || a.sel == SEL_HI);
    endfunction

    function automatic logic is_read_of(acc_t a, sel_e s);
        return a.rd && (a.sel == s);
    endfunction

    function automatic logic is_write_of(acc_t a, sel_e s);
        return a.wr && (a.sel == s);
    endfunction

endpackage

// File: rtl/cc_decode.sv
module cc_decode
    import cc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CTRL_ADDR = 'h103,
    parameter int LO_ADDR   = 'h104,
    parameter int HI_ADDR   = 'h105
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);

    always_comb begin
        acc.rd = rd_en;
        acc.wr = wr_en;
        if (addr == A_CTRL)    acc.sel = SEL_CTRL;
        else if (addr == A_LO) acc.sel = SEL_LO;
        else if (addr == A_HI) acc.sel = SEL_HI;
        else                   acc.sel = SEL_NONE;
    end
endmodule

// File: rtl/cc_counter.sv
module cc_counter
    import cc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic              en_change,
    output logic [CNT_W-1:0]  count
);
    logic en_wr;
    assign en_wr     = is_write_of(acc, SEL_CTRL);
    assign en_change = en_wr && (wdata[CTRL_EN_BIT] != en);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (en_wr) begin
            en <= wdata[CTRL_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (is_write_of(acc, SEL_LO)) begin
            count[DATA_W-1:0] <= wdata;
        end else if (is_write_of(acc, SEL_HI)) begin
            count[CNT_W-1:DATA_W] <= wdata;
        end else if (en) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cc_snapshot.sv
module cc_snapshot
    import cc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic [CNT_W-1:0] count,
    input  logic             disturb,
    output logic [CNT_W-1:0] snap,
    output logic             valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (is_read_of(acc, SEL_LO)) begin
            snap <= count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else if (disturb) begin
            valid <= 1'b0;
        end else if (is_read_of(acc, SEL_LO)) begin
            valid <= 1'b1;
        end else if (is_read_of(acc, SEL_CTRL)) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cyc_counter64.sv
module cyc_counter64
    import cc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CTRL_ADDR = 'h103,
    parameter int LO_ADDR   = 'h104,
    parameter int HI_ADDR   = 'h105
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int OK_BIT = DATA_W - 1;

    acc_t             acc;
    logic             en;
    logic             en_change;
    logic             disturb;
    logic             valid;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] snap;

    cc_decode #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
        .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) u_dec (
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .acc(acc)
    );

    cc_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .acc(acc), .wdata(wdata),
        .en(en), .en_change(en_change), .count(count)
    );

    assign disturb = en_change || is_cnt_write(acc);

    cc_snapshot #(.DATA_W(DATA_W)) u_snap (
        .clk(clk), .rst(rst), .acc(acc), .count(count),
        .disturb(disturb), .snap(snap), .valid(valid)
    );

    always_comb begin
        rdata = '0;
        unique case (acc.sel)
            SEL_CTRL: begin
                rdata[CTRL_EN_BIT] = en;
                rdata[OK_BIT]      = valid;
            end
            SEL_LO:   rdata = count[DATA_W-1:0];
            SEL_HI:   rdata = snap[CNT_W-1:DATA_W];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cc_chk.sv
module cc_chk #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CTRL_ADDR = 'h103,
    parameter int LO_ADDR   = 'h104,
    parameter int HI_ADDR   = 'h105,
    localparam int CNT_W    = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              en,
    input logic              valid,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  snap
);
    logic lo_rd, ctrl_rd, cnt_wr;
    assign lo_rd   = rd_en && (addr == ADDR_W'(LO_ADDR));
    assign ctrl_rd = rd_en && (addr == ADDR_W'(CTRL_ADDR));
    assign cnt_wr  = wr_en && (addr == ADDR_W'(LO_ADDR) || addr == ADDR_W'(HI_ADDR));

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !cnt_wr) |=> (count == $past(count) + CNT_W'(1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> $stable(count));

    // R5
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> (snap == $past(count)));

    // R6
    valid_set_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_rd && !wr_en) |=> valid);

    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |=> !valid);

    // R7
    tear_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !valid);

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |-> (rdata[DATA_W-2:1] == '0));
endmodule

bind cyc_counter64 cc_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .rdata(rdata), .en(en), .valid(valid), .count(count), .snap(snap)
);

// File: tb/tb_cyc_counter64.sv
module tb_cyc_counter64;
    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LO   = 12'h104;
    localparam logic [11:0] A_HI   = 12'h105;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    logic [63:0] m_cnt  = '0;
    logic [63:0] m_snap = '0;
    logic        m_en   = 1'b0;
    logic        m_val  = 1'b0;

    always #5 clk = ~clk;

    cyc_counter64 dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == A_CTRL) return {m_val, 30'b0, m_en};
        if (a == A_LO)   return m_cnt[31:0];
        if (a == A_HI)   return m_snap[63:32];
        return 32'h0;
    endfunction

    // one bus cycle, entered and left at a falling edge
    task automatic op(input logic rd, input logic wr, input logic [11:0] a,
                      input logic [31:0] w, output logic [31:0] r, output logic [31:0] e);
        logic [63:0] nc;
        logic        cw;
        logic        nen;
        rd_en = rd; wr_en = wr; addr = a; wdata = w;
        #1;
        r  = rdata;
        e  = model_read(a);
        nc = m_cnt; cw = 1'b0; nen = m_en;
        if (wr) begin
            if (a == A_CTRL) begin
                if (w[0] != m_en) m_val = 1'b0;
                nen = w[0];
            end else if (a == A_LO) begin
                nc[31:0] = w; cw = 1'b1;
            end else if (a == A_HI) begin
                nc[63:32] = w; cw = 1'b1;
            end
        end
        if (rd) begin
            if (a == A_LO) begin
                m_snap = m_cnt; m_val = 1'b1;
            end else if (a == A_CTRL) begin
                m_val = 1'b0;
            end
        end
        if (cw) m_val = 1'b0;
        else if (m_en) nc = m_cnt + 64'd1;
        m_cnt = nc;
        m_en  = nen;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        logic [31:0] r, e;
        op(1'b1, 1'b0, a, 32'h0, r, e);
        chk(tag, r, e);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] w);
        logic [31:0] r, e;
        op(1'b0, 1'b1, a, w, r, e);
    endtask

    task automatic idle(input int n);
        logic [31:0] r, e;
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 12'h000, 32'h0, r, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(A_CTRL, "R1 ctrl after reset");
        rd_chk(A_LO,   "R1 low after reset");
        rd_chk(A_HI,   "R1 high after reset");
        rd_chk(A_CTRL, "R11 ctrl read without low read");

        // R3 disabled holds
        idle(3);
        rd_chk(A_LO, "R3 disabled count holds");

        // R2 enable, unused bits zero
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk(A_CTRL, "R2 enable readback and zero bits");
        idle(4);
        rd_chk(A_LO, "R3 count advances");
        rd_chk(A_LO, "R3 count advances by one");

        // R5/R6 sweep around the 32-bit carry, varied read spacing
        for (int off = 1; off <= 6; off++) begin
            for (int gap = 0; gap <= 3; gap++) begin
                wr(A_HI, 32'h0000_00A0 + off);
                wr(A_LO, 32'hFFFF_FFFF - off);
                idle(gap);
                rd_chk(A_LO, "R5 low word near carry");
                idle(gap);
                rd_chk(A_HI, "R5 high word from snapshot");
                rd_chk(A_CTRL, "R6 pair valid");
                rd_chk(A_CTRL, "R6 flag cleared by control read");
            end
        end

        // R4 wrap of the full count
        wr(A_HI, 32'hFFFF_FFFF);
        wr(A_LO, 32'hFFFF_FFFD);
        rd_chk(A_LO, "R4 low before wrap");
        rd_chk(A_HI, "R4 high before wrap");
        idle(2);
        rd_chk(A_LO, "R4 low after wrap");
        rd_chk(A_HI, "R4 high after wrap");

        // R7 count writes between low read and control read
        rd_chk(A_LO, "R7 low read");
        wr(A_HI, 32'h1234_5678);
        rd_chk(A_CTRL, "R7 high write tears pair");
        rd_chk(A_LO, "R7 low read");
        wr(A_LO, 32'h0000_0010);
        rd_chk(A_CTRL, "R7 low write tears pair");

        // R9 load priority over increment
        wr(A_LO, 32'hCAFE_0000);
        rd_chk(A_LO, "R9 loaded low word");
        rd_chk(A_HI, "R9 loaded high word");

        // R8 enable changes
        rd_chk(A_LO, "R8 low read");
        wr(A_CTRL, 32'h0000_0001);
        rd_chk(A_CTRL, "R8 same enable keeps flag");
        rd_chk(A_LO, "R8 low read");
        wr(A_CTRL, 32'h0000_0000);
        rd_chk(A_CTRL, "R8 enable change drops flag");
        idle(2);
        rd_chk(A_LO, "R3 held after disable");
        rd_chk(A_LO, "R8 low read while disabled");
        wr(A_CTRL, 32'h0000_0001);
        rd_chk(A_CTRL, "R8 re-enable drops flag");

        // R10 unmapped addresses
        for (int a = 12'h100; a <= 12'h108; a++) begin
            if (a < 12'h103 || a > 12'h105) begin
                rd_chk(a[11:0], "R10 unmapped read is zero");
                rd_chk(A_LO, "R10 low read");
                wr(a[11:0], 32'hFFFF_FFFF);
                rd_chk(A_CTRL, "R10 unmapped write leaves flag and enable");
                rd_chk(A_LO, "R10 unmapped write leaves count");
            end
        end
        wr(A_CTRL, 32'h0);
        for (int a = 12'h106; a <= 12'h10A; a++) begin
            wr(a[11:0], 32'h0000_0001);
            rd_chk(A_CTRL, "R10 unmapped write does not enable");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule